// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Coprocessor

This unit sits beside a 16-bit CPU and does its multiplication, multiply-accumulate and division work. The CPU first writes a 7-bit mode word. That word selects the operation and chooses which half of the 32-bit result register the unit shows on its 16-bit result port. The CPU then pulses a start strobe with two 16-bit arguments.

Multiplies, MAC steps, loads, clears and reads finish one cycle after the start. Division runs iteratively and holds `busy_o` high while it works. Every operation ends with a one-cycle `done_o` pulse. The CPU collects a full 32-bit result in two reads: it rewrites the output-half field and samples `res_o` after each write.

Two flags come out of the unit. `ovf_o` reports signed overflow of the accumulation, and `div_err_o` reports a division by zero.

Top module: `mdac_unit`

## Requirements
- R1: The mode register is 7 bits and resets to 0. Bits [3:0] hold the operation code and bits [6:4] hold the output-half select. A write with `mode_we_i` takes effect from the next cycle, and a start uses the registered mode.
- R2: When the output-half select is 1, `res_o` shows result bits [31:16]. For any other select value it shows bits [15:0]. The selector adds no cycle of latency.
- R3: Op 2 multiplies the arguments as unsigned numbers and op 3 multiplies them as signed numbers. Either op writes the 32-bit product to the result register, with `done_o` high in the cycle after the start.
- R4: Op 6 adds the signed product of the arguments to the result register, wrapping modulo 2^32. It sets `ovf_o` to 1 exactly when that addition overflows as a signed 32-bit sum, and to 0 otherwise.
- R5: Op 7 performs the same accumulation as op 6, but ORs the new overflow into `ovf_o`, so a set flag stays set.
- R6: Op 0 clears the result register, `ovf_o` and `div_err_o`. Op 1 loads the result with `arg_a_i` in bits [31:16] and `arg_b_i` in bits [15:0], and clears `ovf_o`.
- R7: Op 4 divides `arg_a_i` by `arg_b_i` as unsigned numbers. The quotient goes to bits [15:0] and the remainder to bits [31:16]. `done_o` is high 17 cycles after the start cycle.
- R8: Op 5 divides as signed numbers. The quotient truncates toward zero and the remainder takes the sign of the dividend. The result wraps to 16 bits (0x8000 / 0xFFFF gives quotient 0x8000). `done_o` is high 18 cycles after the start.
- R9: A zero divisor gives a quotient of 0xFFFF and a remainder equal to the raw dividend. It sets `div_err_o` and keeps the normal cycle count. A later division with a non-zero divisor clears `div_err_o`.
- R10: `busy_o` is high from the cycle after a division start until `done_o` rises. A start while busy is ignored: it changes neither the running division nor the result, and it produces no extra `done_o`.
- R11: Op 8 and codes 9 to 15 leave the result register and both flags unchanged, and still pulse `done_o` one cycle after the start.
- R12: After reset, `busy_o`, `done_o`, `ovf_o`, `div_err_o` and the result register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 7 | Mode word: {output select, operation code} |
| start_i | input | 1 | Operation start strobe |
| arg_a_i | input | 16 | First argument (multiplicand or dividend) |
| arg_b_i | input | 16 | Second argument (multiplier or divisor) |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 16 | Selected half of the result register |
| ovf_o | output | 1 | MAC signed overflow flag |
| div_err_o | output | 1 | Division-by-zero flag |

## Verification
The bench targets these corner cases:
- MAC sums that cross the signed 32-bit limits, and a sticky flag that an accumulation without overflow must not clear. A wrong flag shows up as a lost or spurious `ovf_o`.
- Signed divisions with mixed operand signs, the 0x8000 / -1 wrap, and zero divisors in both modes. A design that applies the wrong sign correction returns a remainder with the wrong sign or a negated quotient.
- A restart strobe in the middle of a division. A design that accepts it corrupts the quotient or emits a second `done_o`.
- Exact done latencies of 17 and 18 cycles, which expose a miscounted iteration loop.

// File: rtl/mdac_pkg.sv
package mdac_pkg;
  localparam int MODE_W = 7;
  localparam int OP_W   = 4;
  localparam int OSEL_W = MODE_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_CLR  = 4'd0,
    OP_LOAD = 4'd1,
    OP_UMUL = 4'd2,
    OP_SMUL = 4'd3,
    OP_UDIV = 4'd4,
    OP_SDIV = 4'd5,
    OP_MAC  = 4'd6,
    OP_MACH = 4'd7,
    OP_READ = 4'd8
  } op_e;

  localparam logic [OSEL_W-1:0] OSEL_HIGH = OSEL_W'(1);

  function automatic logic op_is_div(logic [OP_W-1:0] op);
    return (op == OP_UDIV) || (op == OP_SDIV);
  endfunction
endpackage

// File: rtl/mdac_mul.sv
module mdac_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  input  logic [2*W-1:0] acc_i,
  output logic [2*W-1:0] prod_o,
  output logic [2*W-1:0] mac_o,
  output logic           mac_ovf_o
);
  localparam int RW = 2 * W;

  logic signed [W:0]    ax, bx;
  logic signed [RW-1:0] prod_s, sprod;

  always_comb begin
    // one extra bit turns both unsigned and signed into a signed product
    ax     = {sgn_i & a_i[W-1], a_i};
    bx     = {sgn_i & b_i[W-1], b_i};
    prod_s = ax * bx;
    sprod  = $signed(a_i) * $signed(b_i);
    prod_o = prod_s;
    mac_o  = acc_i + sprod;
    mac_ovf_o = (sprod[RW-1] == acc_i[RW-1]) && (mac_o[RW-1] != acc_i[RW-1]);
  end
endmodule

// File: rtl/mdac_div.sv
module mdac_div #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         dz_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIX} dv_state_e;

  dv_state_e     state_q;
  logic [W-1:0]  q_q, r_q, d_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q, neg_q_q, neg_r_q, dz_q;

  logic [W:0]    rem_w, diff;
  logic          take, last;
  logic [W-1:0]  nq, nr, q_src, r_src;

  function automatic logic [W-1:0] mag(logic [W-1:0] v, logic s);
    return (s && v[W-1]) ? -v : v;
  endfunction

  always_comb begin
    rem_w = {r_q, q_q[W-1]};
    diff  = rem_w - {1'b0, d_q};
    take  = ~diff[W];
    nq    = {q_q[W-2:0], take};
    nr    = take ? diff[W-1:0] : rem_w[W-1:0];
    last  = (cnt_q == CW'(W - 1));
    q_src = (state_q == DV_FIX) ? q_q : nq;
    r_src = (state_q == DV_FIX) ? r_q : nr;
    quo_o = dz_q ? '1 : (neg_q_q ? -q_src : q_src);
    rem_o = dz_q ? dvd_q : (neg_r_q ? -r_src : r_src);
    fin_o = ((state_q == DV_RUN) && last && !sgn_q) || (state_q == DV_FIX);
  end

  assign busy_o = (state_q != DV_IDLE);
  assign dz_o   = dz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DV_IDLE;
      q_q     <= '0;
      r_q     <= '0;
      d_q     <= '0;
      dvd_q   <= '0;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      unique case (state_q)
        DV_IDLE: if (start_i) begin
          state_q <= DV_RUN;
          q_q     <= mag(dvd_i, sgn_i);
          d_q     <= mag(dvs_i, sgn_i);
          r_q     <= '0;
          dvd_q   <= dvd_i;
          cnt_q   <= '0;
          sgn_q   <= sgn_i;
          neg_q_q <= sgn_i & (dvd_i[W-1] ^ dvs_i[W-1]);
          neg_r_q <= sgn_i & dvd_i[W-1];
          dz_q    <= (dvs_i == '0);
        end
        DV_RUN: begin
          q_q   <= nq;
          r_q   <= nr;
          cnt_q <= cnt_q + CW'(1);
          if (last) state_q <= sgn_q ? DV_FIX : DV_IDLE;
        end
        DV_FIX:  state_q <= DV_IDLE;
        default: state_q <= DV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
  import mdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic [W-1:0]      arg_a_i,
  input  logic [W-1:0]      arg_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      res_o,
  output logic              ovf_o,
  output logic              div_err_o
);
  localparam int RW = 2 * W;

  logic [MODE_W-1:0] mode_q;
  logic [RW-1:0]     res_q;
  logic              ovf_q, derr_q, done_q;
  op_e               op;
  logic [OSEL_W-1:0] osel;
  logic              go, div_go, div_busy, div_fin, div_dz;
  logic [W-1:0]      div_quo, div_rem;
  logic [RW-1:0]     prod, mac_sum;
  logic              mac_ovf;

  assign op     = op_e'(mode_q[OP_W-1:0]);
  assign osel   = mode_q[MODE_W-1:OP_W];
  assign go     = start_i && !div_busy;
  assign div_go = go && op_is_div(op);

  mdac_mul #(.W(W)) mul_i (
    .a_i       (arg_a_i),
    .b_i       (arg_b_i),
    .sgn_i     (op == OP_SMUL),
    .acc_i     (res_q),
    .prod_o    (prod),
    .mac_o     (mac_sum),
    .mac_ovf_o (mac_ovf)
  );

  mdac_div #(.W(W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_go),
    .sgn_i   (op == OP_SDIV),
    .dvd_i   (arg_a_i),
    .dvs_i   (arg_b_i),
    .busy_o  (div_busy),
    .fin_o   (div_fin),
    .quo_o   (div_quo),
    .rem_o   (div_rem),
    .dz_o    (div_dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      derr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (go && !op_is_div(op)) || div_fin;
      if (div_fin) begin
        res_q  <= {div_rem, div_quo};
        derr_q <= div_dz;
      end else if (go) begin
        case (op)
          OP_CLR: begin
            res_q  <= '0;
            ovf_q  <= 1'b0;
            derr_q <= 1'b0;
          end
          OP_LOAD: begin
            res_q <= {arg_a_i, arg_b_i};
            ovf_q <= 1'b0;
          end
          OP_UMUL, OP_SMUL: res_q <= prod;
          OP_MAC: begin
            res_q <= mac_sum;
            ovf_q <= mac_ovf;
          end
          OP_MACH: begin
            res_q <= mac_sum;
            ovf_q <= ovf_q | mac_ovf;
          end
          default: ;
        endcase
      end
    end
  end

  assign res_o     = (osel == OSEL_HIGH) ? res_q[RW-1:W] : res_q[W-1:0];
  assign busy_o    = div_busy;
  assign done_o    = done_q;
  assign ovf_o     = ovf_q;
  assign div_err_o = derr_q;
endmodule

// File: rtl/mdac_chk.sv
module mdac_chk
  import mdac_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MODE_W-1:0] mode_q,
  input logic              busy_o,
  input logic              done_o,
  input logic [2*W-1:0]    res_q,
  input logic              ovf_o,
  input logic              div_err_o
);
  logic [OP_W-1:0] op;
  assign op = mode_q[OP_W-1:0];

  assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !op_is_div(op) |=> done_o && !busy_o);

  assert_div_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_is_div(op) |=> busy_o && !done_o);

  assert_busy_holds_res_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_o || $stable(res_q));

  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op == OP_CLR |=> res_q == '0 && !ovf_o && !div_err_o);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op == OP_MACH && ovf_o |=> ovf_o);

  assert_read_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op >= OP_READ |=> $stable(res_q) && $stable(ovf_o) && $stable(div_err_o));
endmodule

bind mdac_unit mdac_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_q    (mode_q),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .res_q     (res_q),
  .ovf_o     (ovf_o),
  .div_err_o (div_err_o)
);

// File: tb/mdac_unit_tb.sv
module mdac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [6:0]  mode = '0;
  logic        start = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        busy, done, ovf, derr;
  logic [15:0] res;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_res = '0;
  logic        m_ovf = 1'b0, m_derr = 1'b0;

  always #4 clk = ~clk;

  mdac_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .start_i(start), .arg_a_i(a), .arg_b_i(b), .busy_o(busy), .done_o(done),
    .res_o(res), .ovf_o(ovf), .div_err_o(derr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic [6:0] v);
    @(negedge clk); mode_we = 1'b1; mode = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic rd_full(logic [3:0] op, output logic [31:0] r);
    wr_mode({3'd1, op}); r[31:16] = res;
    wr_mode({3'd0, op}); r[15:0]  = res;
  endtask

  // bench model of one operation
  task automatic model(logic [3:0] op, logic [15:0] x, logic [15:0] y);
    longint s;
    int sx, sy;
    sx = int'($signed(x)); sy = int'($signed(y));
    case (op)
      4'd0: begin m_res = '0; m_ovf = 0; m_derr = 0; end
      4'd1: begin m_res = {x, y}; m_ovf = 0; end
      4'd2: m_res = 32'(x) * 32'(y);
      4'd3: m_res = 32'(sx * sy);
      4'd4: begin
        if (y == 0) begin m_res = {x, 16'hFFFF}; m_derr = 1; end
        else begin m_res = {16'(x % y), 16'(x / y)}; m_derr = 0; end
      end
      4'd5: begin
        if (y == 0) begin m_res = {x, 16'hFFFF}; m_derr = 1; end
        else begin m_res = {16'(sx % sy), 16'(sx / sy)}; m_derr = 0; end
      end
      4'd6, 4'd7: begin
        s = longint'($signed(m_res)) + longint'(sx * sy);
        m_res = 32'(s);
        if (op == 4'd6) m_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        else m_ovf = m_ovf | (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      default: ;
    endcase
  endtask

  task automatic run_op(string req, logic [3:0] op, logic [15:0] x, logic [15:0] y);
    int cyc;
    logic [31:0] r;
    wr_mode({3'd0, op});
    start = 1'b1; a = x; b = y;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    model(op, x, y);
    if (op == 4'd4) chk({req, " R7 latency"}, cyc, 17);
    else if (op == 4'd5) chk({req, " R8 latency"}, cyc, 18);
    else chk({req, " R3 R11 latency"}, cyc, 1);
    rd_full(op, r);
    chk({req, " result"}, r, m_res);
    chk({req, " ovf R4"}, ovf, m_ovf);
    chk({req, " div_err R9"}, derr, m_derr);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int extra;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy", busy, 0); chk("R12 done", done, 0);
    chk("R12 res", res, 0); chk("R12 ovf", ovf, 0); chk("R12 derr", derr, 0);

    // R1 R2 output half select
    run_op("R6 load", 4'd1, 16'h1234, 16'h5678);
    wr_mode({3'd1, 4'd8}); chk("R2 high", res, 16'h1234);
    wr_mode({3'd5, 4'd8}); chk("R2 other sel", res, 16'h5678);
    wr_mode({3'd0, 4'd8}); chk("R1 R2 low", res, 16'h5678);

    run_op("R3 umul max", 4'd2, 16'hFFFF, 16'hFFFF);
    run_op("R3 smul -1", 4'd3, 16'hFFFF, 16'hFFFF);
    run_op("R3 smul min", 4'd3, 16'h8000, 16'h8000);
    run_op("R6 load near max", 4'd1, 16'h7FFF, 16'hFFFF);
    run_op("R4 mac ovf", 4'd6, 16'h0001, 16'h0001);
    run_op("R4 mac no ovf", 4'd6, 16'h0000, 16'h0000);
    run_op("R6 load near min", 4'd1, 16'h8000, 16'h0000);
    run_op("R5 mach ovf", 4'd7, 16'hFFFF, 16'h0001);
    run_op("R5 mach hold", 4'd7, 16'h0000, 16'h0000);
    run_op("R11 read", 4'd8, 16'h1111, 16'h2222);
    run_op("R11 nop", 4'd13, 16'h3333, 16'h4444);
    run_op("R6 clear", 4'd0, 16'h0, 16'h0);
    run_op("R7 udiv", 4'd4, 16'd100, 16'd7);
    run_op("R8 sdiv neg dvd", 4'd5, 16'hFFF9, 16'd2);
    run_op("R8 sdiv neg dvs", 4'd5, 16'd7, 16'hFFFE);
    run_op("R8 sdiv wrap", 4'd5, 16'h8000, 16'hFFFF);
    run_op("R9 udiv zero", 4'd4, 16'hABCD, 16'h0);
    run_op("R9 clear on good", 4'd4, 16'd9, 16'd3);
    run_op("R9 sdiv zero", 4'd5, 16'hF00D, 16'h0);

    // R10 restart while busy is ignored
    wr_mode({3'd0, 4'd4});
    start = 1'b1; a = 16'd1000; b = 16'd3;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 busy mid", busy, 1);
    start = 1'b1; a = 16'd50; b = 16'd5;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    model(4'd4, 16'd1000, 16'd3);
    extra = 0;
    repeat (25) begin @(negedge clk); if (done) extra++; end
    chk("R10 no extra done", extra, 0);
    rd_full(4'd4, r);
    chk("R10 result kept", r, m_res);

    // constrained random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      logic [15:0] x, y;
      op = 4'($urandom_range(0, 15));
      x = 16'($urandom); y = 16'($urandom);
      if ($urandom_range(0, 9) == 0) y = 16'h0;
      if ($urandom_range(0, 9) == 0) x = 16'h8000;
      run_op("rand", op, x, y);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule